// File: doc/BRIEF.md
# Nibble Bit Set/Clear/Test Unit

This block carries out single-bit operations on a 4-bit data memory word. An instruction word names one of three operations (force a bit high, force a bit low, or sample a bit) and a 2-bit index picks the bit inside the word. For the two writing operations the block reads the addressed word, changes only the chosen bit and returns the result with a write strobe in the same cycle. For the sampling operation it copies the chosen bit into a status flag and never writes.

Each operation comes in two address forms. The pointer form is one word long: the memory address comes from the `ptr_addr` input, which an address unit outside this block supplies. The explicit form is two words long. The first word carries the operation and the index, and the next valid word carries the memory address in its low bits. Memory reads are combinational: `mem_rdata` must follow `mem_addr` within the same cycle.

Top module: `nibble_bitop`

## Requirements
- R1: Instruction word layout (10 bits): [9:4] form prefix, [3:2] operation, [1:0] bit index n. Prefix 6'b001000 selects the pointer form and prefix 6'b101100 selects the explicit form. Operation 2'b01 sets bit n, 2'b10 clears it and 2'b11 tests it. In a set, `mem_we` is 1 and `mem_wdata` equals `mem_rdata` with bit n forced to 1, in the same cycle as the word that performs the operation.
- R2: In a clear, `mem_we` is 1 and `mem_wdata` equals `mem_rdata` with bit n forced to 0, in the same cycle. The other three bits always match `mem_rdata`.
- R3: A test leaves `mem_we` at 0. At the clock edge that ends the performing cycle, `status` takes the value of bit n of `mem_rdata`.
- R4: Set and clear leave `status` unchanged.
- R5: A pointer-form word performs its operation in the cycle it is presented. `mem_addr` equals `ptr_addr` in that cycle.
- R6: An explicit-form first word writes nothing and raises `wait_addr` from the next cycle. The next valid word is taken as the address: `mem_addr` is its low 6 bits and the stored operation is performed in that cycle. `wait_addr` is 0 again afterwards.
- R7: While `wait_addr` is 1, cycles with `instr_valid` low perform nothing, and `wait_addr` stays 1.
- R8: A word with another prefix, with operation 2'b00, or with `instr_valid` low is ignored. It causes no write, `status` keeps its value and `wait_addr` stays 0.
- R9: After reset `status` is 0, `wait_addr` is 0 and `mem_we` is 0 while `instr_valid` is low.
- R10: `mem_we` is never 1 in a cycle where `instr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 10 | Instruction word, or the address word of an explicit form |
| ptr_addr | input | 6 | Memory address used by the pointer forms |
| mem_addr | output | 6 | Address presented to the data memory |
| mem_rdata | input | 4 | Word read combinationally at `mem_addr` |
| mem_wdata | output | 4 | Modified word to write back |
| mem_we | output | 1 | Write strobe for `mem_wdata` |
| status | output | 1 | Condition flag loaded by a test |
| wait_addr | output | 1 | An explicit form is waiting for its address word |

## Verification
The block holds little state. If the pending operation or index it saves for an explicit form is wrong, the fault appears at the ports in the very next valid cycle, either as the wrong bit changed in `mem_wdata` or as a write strobe where a test should have left memory alone. If the wait flag is wrong, the address word is decoded as an instruction, so `mem_addr` follows `ptr_addr` in that same cycle and the target word stays unchanged. A corrupted status flag shows one cycle after the test that loads it, and also whenever a set or clear fails to hold it.

// File: rtl/nibble_bitop.sv
module nibble_bitop #(
  parameter int AW      = 6,
  parameter int DW      = 4,
  parameter int IW      = 10,
  parameter int PTR_PRE = 'b001000,
  parameter int EXP_PRE = 'b101100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          status,
  output logic          wait_addr
);
  localparam int NW = $clog2(DW);
  localparam int PW = IW - 2 - NW;
  localparam logic [1:0] OP_SET = 2'b01;
  localparam logic [1:0] OP_CLR = 2'b10;
  localparam logic [1:0] OP_TST = 2'b11;

  logic [PW-1:0] pre_w;
  logic [1:0]    op_w, op_q, eop;
  logic [NW-1:0] idx_w, idx_q, eidx;
  logic          is_op, ptr_go, exp_first, exec;
  logic [DW-1:0] mask;

  assign pre_w = instr[IW-1:NW+2];
  assign op_w  = instr[NW+1:NW];
  assign idx_w = instr[NW-1:0];

  assign is_op     = instr_valid && !wait_addr && (op_w != 2'b00);
  assign ptr_go    = is_op && (pre_w == PW'(PTR_PRE));
  assign exp_first = is_op && (pre_w == PW'(EXP_PRE));
  assign exec      = ptr_go || (instr_valid && wait_addr);

  assign eop  = wait_addr ? op_q  : op_w;
  assign eidx = wait_addr ? idx_q : idx_w;
  assign mask = DW'(1) << eidx;

  assign mem_addr  = wait_addr ? instr[AW-1:0] : ptr_addr;
  assign mem_we    = exec && (eop == OP_SET || eop == OP_CLR);
  assign mem_wdata = (eop == OP_SET) ? (mem_rdata | mask) : (mem_rdata & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_addr <= 1'b0;
      op_q      <= 2'b00;
      idx_q     <= '0;
      status    <= 1'b0;
    end else begin
      if (exp_first) begin
        wait_addr <= 1'b1;
        op_q      <= op_w;
        idx_q     <= idx_w;
      end else if (instr_valid) begin
        wait_addr <= 1'b0;
      end
      if (exec && eop == OP_TST)
        status <= mem_rdata[eidx];
    end
  end
endmodule

module nibble_bitop_chk #(
  parameter int AW      = 6,
  parameter int DW      = 4,
  parameter int IW      = 10,
  parameter int EXP_PRE = 'b101100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          status,
  input logic          wait_addr
);
  localparam int NW = $clog2(DW);
  localparam int PW = IW - 2 - NW;
  logic exp_word;
  assign exp_word = instr_valid && !wait_addr &&
                    instr[IW-1:NW+2] == PW'(EXP_PRE) && instr[NW+1:NW] != 2'b00;

  assert_single_bit_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $countones(mem_wdata ^ mem_rdata) <= 1);
  assert_we_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> instr_valid);
  assert_status_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $past(instr_valid));
  assert_first_word_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_word |-> !mem_we);
  assert_first_word_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_word |=> wait_addr);
  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_addr && !instr_valid) |=> wait_addr);
  assert_idle_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_addr && !instr_valid) |=> !wait_addr);
endmodule

bind nibble_bitop nibble_bitop_chk #(.AW(AW), .DW(DW), .IW(IW), .EXP_PRE(EXP_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .status(status), .wait_addr(wait_addr)
);

// File: tb/nibble_bitop_test.sv
`timescale 1ns/1ps
module nibble_bitop_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [9:0] instr = '0;
  logic [5:0] ptr_addr = '0;
  logic [5:0] mem_addr;
  logic [3:0] mem_rdata, mem_wdata;
  logic       mem_we, status, wait_addr;
  logic [3:0] mem [64];
  int errors = 0, checks = 0;
  bit done = 1'b0;

  localparam logic [5:0] PTR = 6'b001000;
  localparam logic [5:0] EXP = 6'b101100;

  always #4 clk = ~clk;

  nibble_bitop uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ptr_addr(ptr_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .status(status), .wait_addr(wait_addr)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // {op, n, addr, initial word, expected word, expected status}
  localparam logic [18:0] VEC [8] = '{
    {2'd1, 2'd0, 6'd5,  4'b0000, 4'b0001, 1'b0},
    {2'd3, 2'd0, 6'd5,  4'b0001, 4'b0001, 1'b1},
    {2'd2, 2'd3, 6'd9,  4'b1111, 4'b0111, 1'b1},
    {2'd3, 2'd3, 6'd9,  4'b0111, 4'b0111, 1'b0},
    {2'd1, 2'd2, 6'd63, 4'b1010, 4'b1110, 1'b0},
    {2'd2, 2'd1, 6'd0,  4'b1010, 4'b1000, 1'b0},
    {2'd3, 2'd2, 6'd12, 4'b0100, 4'b0100, 1'b1},
    {2'd1, 2'd3, 6'd12, 4'b1000, 4'b1000, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] w, input logic v);
    @(negedge clk);
    instr = w;
    instr_valid = v;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 4'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 status", status, 0);
    check("R9 wait_addr", wait_addr, 0);
    check("R9 mem_we", mem_we, 0);

    for (int k = 0; k < 8; k++) begin
      logic [1:0] op;
      logic [1:0] n;
      logic [5:0] a;
      {op, n, a} = VEC[k][18:9];
      mem[a] = VEC[k][8:5];
      ptr_addr = a;
      put({PTR, op, n}, 1'b1);
      check("R5 mem_addr", mem_addr, a);
      if (op == 2'd3) check("R3 no write on test", mem_we, 0);
      else begin
        check(op == 2'd1 ? "R1 we" : "R2 we", mem_we, 1);
        check(op == 2'd1 ? "R1 wdata" : "R2 wdata", mem_wdata, VEC[k][4:1]);
      end
      put('0, 1'b0);
      check("R1 R2 R3 stored word", mem[a], VEC[k][4:1]);
      check(op == 2'd3 ? "R3 status" : "R4 status held", status, VEC[k][0]);
    end

    // explicit-form set of bit 2 at address 33, pointer aimed elsewhere
    mem[33] = 4'b0001; mem[7] = 4'b0000; ptr_addr = 6'd7;
    put({EXP, 2'b01, 2'd2}, 1'b1);
    check("R6 first word no write", mem_we, 0);
    put(10'd33, 1'b1);
    check("R6 wait_addr raised", wait_addr, 1);
    check("R6 mem_addr from second word", mem_addr, 33);
    check("R6 we on second word", mem_we, 1);
    put('0, 1'b0);
    check("R6 target word", mem[33], 4'b0101);
    check("R6 pointer word untouched", mem[7], 4'b0000);
    check("R6 wait_addr cleared", wait_addr, 0);
    check("R4 status after explicit set", status, 1);

    // explicit-form test with idle gap
    mem[20] = 4'b0010;
    put({EXP, 2'b11, 2'd1}, 1'b1);
    put('0, 1'b0);
    check("R7 no write while waiting", mem_we, 0);
    put('0, 1'b0);
    check("R7 wait held", wait_addr, 1);
    put(10'd20, 1'b1);
    check("R3 explicit test no write", mem_we, 0);
    put('0, 1'b0);
    check("R3 explicit test status", status, 1);
    check("R6 wait cleared after test", wait_addr, 0);

    // explicit clear of bit 1 at 20 leaves status
    put({EXP, 2'b10, 2'd1}, 1'b1);
    put(10'd20, 1'b1);
    check("R2 explicit clear wdata", mem_wdata, 4'b0000);
    put('0, 1'b0);
    check("R2 explicit clear word", mem[20], 4'b0000);
    check("R4 status kept by clear", status, 1);

    // ignored words
    mem[7] = 4'b0000;
    put({6'b111111, 2'b01, 2'd0}, 1'b1);
    check("R8 foreign prefix no write", mem_we, 0);
    put({PTR, 2'b00, 2'd0}, 1'b1);
    check("R8 op zero no write", mem_we, 0);
    put({EXP, 2'b00, 2'd3}, 1'b1);
    check("R8 explicit op zero no write", mem_we, 0);
    put({PTR, 2'b01, 2'd0}, 1'b0);
    check("R10 invalid word no write", mem_we, 0);
    put('0, 1'b0);
    check("R8 wait stays low", wait_addr, 0);
    check("R8 word untouched", mem[7], 4'b0000);
    check("R8 status kept", status, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule